// File: doc/BRIEF.md
# Single-Precision Multiplier with Jamming Rounding

This block multiplies two IEEE 754 single-precision numbers over several clock cycles and returns the packed 32-bit product together with overflow, underflow and invalid flags. A one-cycle `start` pulse, sampled only while the block is idle, captures both operands. The block then classifies each operand as zero, denormal, normal, infinity or NaN. When either operand is special, the result is decided at once and no multiplication takes place.

For two finite nonzero operands, each 24-bit significand is held in a 32-bit register and split into a high and a low 16-bit half. One shared 16x16 multiplier forms one cross product per cycle. Each cross product is shifted by 0, 16 or 32 bits and added into a 64-bit accumulator held as an upper and a lower word. The exponent is the sum of the operand exponents less the bias of 127, and the sign is the XOR of the operand signs. A normalize step moves the leading one to the top of a 24-bit kept field and corrects the exponent by the shift amount. Every bit below that field is ORed into the kept LSB (jamming). A final step checks the exponent range and packs sign, exponent and the 23 fraction bits, with the leading one hidden.

Top module: `spmul_jam`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `ovf`, `unf`, `inv` and `prod_out` are all 0.
- R2: For finite nonzero operands, the product has sign = sign_a XOR sign_b and biased exponent = exp_a + exp_b - 127, corrected by normalization. `done` is high for exactly one cycle, at the 7th rising edge counting the edge that samples `start`.
- R3: Jamming: if any product bit below the 24 kept significand bits is 1, fraction bit 0 of the result is forced to 1. Otherwise the kept bits pass through unchanged.
- R4: Zero times a finite value gives a zero with sign = sign_a XOR sign_b and no flag set. `done` rises at the 2nd edge counting the start edge.
- R5: A NaN operand, or zero times infinity, gives 0x7FC00000 with `inv` = 1. `done` rises at the 2nd edge.
- R6: Infinity times a nonzero value that is not NaN gives infinity (exponent field 0xFF, fraction 0) with the XORed sign and no flag set. `done` rises at the 2nd edge.
- R7: If the normalized biased exponent is 255 or more, `ovf` = 1 and the result is infinity with the product's sign. At most one of `ovf`, `unf` and `inv` is 1.
- R8: If the normalized biased exponent is 0 or less, `unf` = 1 and the result is a zero with the product's sign.
- R9: A denormal operand (exponent field 0, fraction nonzero) is used with exponent 1 and no hidden bit. The product is normalized by left shifts.
- R10: A `start` that arrives while an operation is in progress is ignored. The result belongs to the operands captured in idle, and no extra `done` follows.
- R11: `prod_out` and the flags change only in the cycle in which `done` is high, and hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation; sampled only when idle |
| a_in | input | 32 | First single-precision operand |
| b_in | input | 32 | Second single-precision operand |
| prod_out | output | 32 | Packed single-precision product |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Exponent overflow on the last operation |
| unf | output | 1 | Exponent underflow on the last operation |
| inv | output | 1 | Invalid operation on the last operation |

## Verification
For two finite nonzero operands, the result and flags are due at the 7th rising edge counting the edge that samples `start`: four partial-product cycles, one normalize cycle and one pack cycle. For zero, infinity and NaN operands they are due at the 2nd edge. Every scenario task drives its inputs on a falling edge and counts rising edges up to the falling edge at which `done` is first seen high. It checks that count against 7 or 2, reads `prod_out` and the flags at that same falling edge, and then watches further falling edges to confirm that no extra `done` appears and that the outputs hold.

// File: rtl/spmul_pkg.sv
package spmul_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int HALF_W  = 16;
    localparam int REG_W   = 2 * HALF_W;
    localparam int ACC_W   = 2 * REG_W;
    localparam int LZ_W    = $clog2(ACC_W);
    localparam int EXT_W   = EXP_W + 4;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [2:0] {
        S_IDLE, S_PP0, S_PP1, S_PP2, S_PP3, S_NORM, S_PACK
    } state_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp_eff;
        logic [SIG_W-1:0] sig;
        logic             zero;
        logic             inf;
        logic             nan;
    } opnd_t;
endpackage

// File: rtl/spmul_unpack.sv
module spmul_unpack
    import spmul_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output opnd_t             info
);
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    logic              ex_zero;
    logic              ex_ones;
    logic              fr_zero;

    always_comb begin
        ex      = word[WORD_W-2 -: EXP_W];
        fr      = word[FRAC_W-1:0];
        ex_zero = (ex == '0);
        ex_ones = (ex == '1);
        fr_zero = (fr == '0);

        info.sign    = word[WORD_W-1];
        info.exp_eff = ex_zero ? EXP_W'(1) : ex;
        info.sig     = {~ex_zero, fr};
        info.zero    = ex_zero & fr_zero;
        info.inf     = ex_ones & fr_zero;
        info.nan     = ex_ones & ~fr_zero;
    end
endmodule

// File: rtl/spmul_pp_mul.sv
module spmul_pp_mul
    import spmul_pkg::*;
(
    input  logic [1:0]       sel,
    input  logic [REG_W-1:0] opa,
    input  logic [REG_W-1:0] opb,
    output logic [ACC_W-1:0] term
);
    logic [HALF_W-1:0] x;
    logic [HALF_W-1:0] y;
    logic [REG_W-1:0]  prod;

    always_comb begin
        x    = sel[0] ? opa[REG_W-1:HALF_W] : opa[HALF_W-1:0];
        y    = sel[1] ? opb[REG_W-1:HALF_W] : opb[HALF_W-1:0];
        prod = x * y;
        case (sel)
            2'd0:    term = ACC_W'(prod);
            2'd3:    term = ACC_W'(prod) << (2 * HALF_W);
            default: term = ACC_W'(prod) << HALF_W;
        endcase
    end
endmodule

// File: rtl/spmul_norm.sv
module spmul_norm
    import spmul_pkg::*;
(
    input  logic [ACC_W-1:0] prod,
    input  logic [EXT_W-1:0] exp_in,
    output logic [SIG_W-1:0] kept,
    output logic [EXT_W-1:0] exp_out
);
    logic [LZ_W-1:0]  msb;
    logic [LZ_W-1:0]  lz;
    logic [ACC_W-1:0] shifted;
    logic             sticky;

    always_comb begin
        msb = '0;
        for (int i = 0; i < ACC_W; i++) begin
            if (prod[i]) msb = LZ_W'(i);
        end
        lz      = LZ_W'(ACC_W - 1) - msb;
        shifted = prod << lz;
        sticky  = |shifted[ACC_W-SIG_W-1:0];
        kept    = shifted[ACC_W-1 -: SIG_W] | SIG_W'(sticky);
        // leading one at bit 2*SIG_W-1 of the product means a shift count of
        // ACC_W-2*SIG_W and an exponent increment of one
        exp_out = exp_in + EXT_W'(ACC_W - 2 * SIG_W + 1) - EXT_W'(lz);
    end
endmodule

// File: rtl/spmul_jam.sv
module spmul_jam
    import spmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    output logic [WORD_W-1:0] prod_out,
    output logic              done,
    output logic              ovf,
    output logic              unf,
    output logic              inv
);
    typedef struct packed {
        state_e            st;
        logic              sign;
        logic [EXT_W-1:0]  exp;
        logic [REG_W-1:0]  sa;
        logic [REG_W-1:0]  sb;
        logic [REG_W-1:0]  acc_hi;
        logic [REG_W-1:0]  acc_lo;
        logic [SIG_W-1:0]  kept;
        logic              spec;
        logic              spec_inv;
        logic [WORD_W-1:0] spec_res;
        logic [WORD_W-1:0] res;
        logic              done;
        logic              ovf;
        logic              unf;
        logic              inv;
    } regs_t;

    regs_t r_q, r_d;

    logic [WORD_W-1:0] ops [2];
    opnd_t             cls [2];

    assign ops[0] = a_in;
    assign ops[1] = b_in;

    for (genvar g = 0; g < 2; g++) begin : g_unpack
        spmul_unpack u_unpack (
            .word (ops[g]),
            .info (cls[g])
        );
    end

    logic [1:0]       pp_sel;
    logic [ACC_W-1:0] pp_term;
    logic [SIG_W-1:0] n_kept;
    logic [EXT_W-1:0] n_exp;

    always_comb begin
        case (r_q.st)
            S_PP1:   pp_sel = 2'd1;
            S_PP2:   pp_sel = 2'd2;
            S_PP3:   pp_sel = 2'd3;
            default: pp_sel = 2'd0;
        endcase
    end

    spmul_pp_mul u_pp (
        .sel  (pp_sel),
        .opa  (r_q.sa),
        .opb  (r_q.sb),
        .term (pp_term)
    );

    spmul_norm u_norm (
        .prod    ({r_q.acc_hi, r_q.acc_lo}),
        .exp_in  (r_q.exp),
        .kept    (n_kept),
        .exp_out (n_exp)
    );

    logic any_nan, any_inf, any_zero, bad_op, s_x;

    always_comb begin
        any_nan  = cls[0].nan | cls[1].nan;
        any_inf  = cls[0].inf | cls[1].inf;
        any_zero = cls[0].zero | cls[1].zero;
        bad_op   = any_nan | (any_inf & any_zero);
        s_x      = cls[0].sign ^ cls[1].sign;

        r_d      = r_q;
        r_d.done = 1'b0;

        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.sign     = s_x;
                    r_d.spec     = 1'b1;
                    r_d.spec_inv = 1'b0;
                    r_d.st       = S_PACK;
                    if (bad_op) begin
                        r_d.spec_inv = 1'b1;
                        r_d.spec_res = QNAN_WORD;
                    end else if (any_inf) begin
                        r_d.spec_res = {s_x, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                    end else if (any_zero) begin
                        r_d.spec_res = {s_x, {(WORD_W-1){1'b0}}};
                    end else begin
                        r_d.spec   = 1'b0;
                        r_d.sa     = REG_W'(cls[0].sig);
                        r_d.sb     = REG_W'(cls[1].sig);
                        r_d.exp    = EXT_W'(cls[0].exp_eff) + EXT_W'(cls[1].exp_eff)
                                   - EXT_W'(BIAS);
                        r_d.acc_hi = '0;
                        r_d.acc_lo = '0;
                        r_d.st     = S_PP0;
                    end
                end
            end
            S_PP0, S_PP1, S_PP2, S_PP3: begin
                {r_d.acc_hi, r_d.acc_lo} = {r_q.acc_hi, r_q.acc_lo} + pp_term;
                case (r_q.st)
                    S_PP0:   r_d.st = S_PP1;
                    S_PP1:   r_d.st = S_PP2;
                    S_PP2:   r_d.st = S_PP3;
                    default: r_d.st = S_NORM;
                endcase
            end
            S_NORM: begin
                r_d.kept = n_kept;
                r_d.exp  = n_exp;
                r_d.st   = S_PACK;
            end
            S_PACK: begin
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
                r_d.ovf  = 1'b0;
                r_d.unf  = 1'b0;
                r_d.inv  = 1'b0;
                if (r_q.spec) begin
                    r_d.res = r_q.spec_res;
                    r_d.inv = r_q.spec_inv;
                end else if ($signed(r_q.exp) >= $signed(EXT_W'(EXP_MAX))) begin
                    r_d.ovf = 1'b1;
                    r_d.res = {r_q.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                end else if ($signed(r_q.exp) < $signed(EXT_W'(1))) begin
                    r_d.unf = 1'b1;
                    r_d.res = {r_q.sign, {(WORD_W-1){1'b0}}};
                end else begin
                    r_d.res = {r_q.sign, r_q.exp[EXP_W-1:0], r_q.kept[FRAC_W-1:0]};
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign prod_out = r_q.res;
    assign done     = r_q.done;
    assign ovf      = r_q.ovf;
    assign unf      = r_q.unf;
    assign inv      = r_q.inv;
endmodule

// File: rtl/spmul_jam_chk.sv
module spmul_jam_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] prod_out,
    input logic        done,
    input logic        ovf,
    input logic        unf,
    input logic        inv
);
    // R2: completion is a single-cycle pulse
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: the invalid flag always comes with the quiet NaN word
    a_r5_invalid_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        inv |-> (prod_out == 32'h7FC0_0000));

    // R7: overflow always delivers an infinity
    a_r7_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (prod_out[30:0] == 31'h7F80_0000));

    // R7: the three flags never overlap
    a_r7_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf, unf, inv}));

    // R8: underflow always delivers a zero
    a_r8_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> (prod_out[30:0] == 31'h0));

    // R11: outputs move only together with done
    a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(prod_out) && $stable({ovf, unf, inv})));
endmodule

bind spmul_jam spmul_jam_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .prod_out (prod_out),
    .done     (done),
    .ovf      (ovf),
    .unf      (unf),
    .inv      (inv)
);

// File: tb/tb_spmul_jam.sv
module tb_spmul_jam;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic [31:0] prod_out;
    logic        done, ovf, unf, inv;

    int checks = 0;
    int errors = 0;

    localparam int LAT_FULL = 7;
    localparam int LAT_SPEC = 2;

    always #5 clk = ~clk;

    spmul_jam dut (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
        .prod_out(prod_out), .done(done), .ovf(ovf), .unf(unf), .inv(inv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one operation; lat counts rising edges including the start edge
    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] res, output logic [2:0] fl, output int lat);
        @(negedge clk);
        a_in = a; b_in = b; start = 1'b1; lat = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 30);
        res = prod_out;
        fl  = {ovf, unf, inv};
    endtask

    task automatic do_case(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] exp_res, input logic [2:0] exp_fl,
                           input int exp_lat);
        logic [31:0] res;
        logic [2:0]  fl;
        int          lat;
        run_op(a, b, res, fl, lat);
        chk({tag, " result"}, res, exp_res);
        chk({tag, " flags ovf/unf/inv"}, 32'(fl), 32'(exp_fl));
        chk({tag, " latency"}, 32'(lat), 32'(exp_lat));
    endtask

    task automatic t_reset();
        chk("R1 reset done", 32'(done), 32'd0);
        chk("R1 reset prod_out", prod_out, 32'h0);
        chk("R1 reset flags", 32'({ovf, unf, inv}), 32'd0);
    endtask

    task automatic t_normal();
        do_case("R2 1.5x2", 32'h3FC0_0000, 32'h4000_0000, 32'h4040_0000, 3'b000, LAT_FULL);
        do_case("R2 -1.5x2 sign", 32'hBFC0_0000, 32'h4000_0000, 32'hC040_0000, 3'b000, LAT_FULL);
        do_case("R2 1.5x1.5 carry", 32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000, 3'b000, LAT_FULL);
        @(negedge clk);
        chk("R2 done single pulse", 32'(done), 32'd0);
    endtask

    task automatic t_jam();
        // (1+2^-23)^2: discarded bits nonzero, LSB forced to 1 (truncation gives ...02)
        do_case("R3 jam low range", 32'h3F80_0001, 32'h3F80_0001, 32'h3F80_0003, 3'b000, LAT_FULL);
        // largest significand squared: upper range, sticky set
        do_case("R3 jam high range", 32'h3FFF_FFFF, 32'h3FFF_FFFF, 32'h407F_FFFF, 3'b000, LAT_FULL);
        // exact product keeps bits unchanged
        do_case("R3 exact no jam", 32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000, 3'b000, LAT_FULL);
    endtask

    task automatic t_zero();
        do_case("R4 zero x neg", 32'h0000_0000, 32'hC040_0000, 32'h8000_0000, 3'b000, LAT_SPEC);
        do_case("R4 pos x zero", 32'h4040_0000, 32'h0000_0000, 32'h0000_0000, 3'b000, LAT_SPEC);
    endtask

    task automatic t_invalid();
        do_case("R5 nan operand", 32'h7FC0_0001, 32'h3F80_0000, 32'h7FC0_0000, 3'b001, LAT_SPEC);
        do_case("R5 zero x inf", 32'h0000_0000, 32'hFF80_0000, 32'h7FC0_0000, 3'b001, LAT_SPEC);
    endtask

    task automatic t_inf();
        do_case("R6 -inf x 2", 32'hFF80_0000, 32'h4000_0000, 32'hFF80_0000, 3'b000, LAT_SPEC);
        do_case("R6 -2 x -inf", 32'hC000_0000, 32'hFF80_0000, 32'h7F80_0000, 3'b000, LAT_SPEC);
    endtask

    task automatic t_ovf();
        do_case("R7 overflow pos", 32'h7F00_0000, 32'h4000_0000, 32'h7F80_0000, 3'b100, LAT_FULL);
        do_case("R7 overflow neg", 32'hFF00_0000, 32'h4000_0000, 32'hFF80_0000, 3'b100, LAT_FULL);
    endtask

    task automatic t_unf();
        do_case("R8 underflow pos", 32'h0080_0000, 32'h3F00_0000, 32'h0000_0000, 3'b010, LAT_FULL);
        do_case("R8 underflow neg", 32'h0080_0000, 32'hBF00_0000, 32'h8000_0000, 3'b010, LAT_FULL);
    endtask

    task automatic t_denorm();
        // 2^-127 (denormal) x 2^127 = 1.0
        do_case("R9 denormal x big", 32'h0040_0000, 32'h7F00_0000, 32'h3F80_0000, 3'b000, LAT_FULL);
    endtask

    task automatic t_busy();
        int lat;
        int extra;
        @(negedge clk);
        a_in = 32'h3FC0_0000; b_in = 32'h4000_0000; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        a_in = 32'h7FC0_0001; b_in = 32'h0000_0000; start = 1'b1;
        lat = 1;
        do begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 30);
        chk("R10 busy start result", prod_out, 32'h4040_0000);
        chk("R10 busy start flags", 32'({ovf, unf, inv}), 32'd0);
        chk("R10 busy start latency", 32'(lat), 32'(LAT_FULL));
        extra = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R10 no second done", 32'(extra), 32'd0);
    endtask

    task automatic t_hold();
        logic [31:0] res;
        logic [2:0]  fl;
        int          lat;
        int          moved;
        run_op(32'h7F00_0000, 32'h4000_0000, res, fl, lat);
        moved = 0;
        a_in = 32'h3F80_0000; b_in = 32'h3F80_0000;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (prod_out !== res || {ovf, unf, inv} !== fl) moved++;
        end
        chk("R11 outputs hold", 32'(moved), 32'd0);
        chk("R11 held ovf flag", 32'({ovf, unf, inv}), 32'(3'b100));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_jam();
        t_zero();
        t_invalid();
        t_inf();
        t_ovf();
        t_unf();
        t_denorm();
        t_busy();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule